// File: doc/BRIEF.md
# Serial Pixel Word Receiver

This block turns a one-bit serial video line into parallel pixel words. Every pixel period carries one 30-bit frame, and the receiver samples one bit per clock on a bit clock that runs thirty times faster than the pixel rate. Each frame holds 24 pixel bits, 3 control bits, one parity bit, and a start marker and a stop marker. The block finds where frames begin from those markers. It checks every frame's parity before the frame may reach the parallel outputs.

A good frame updates the 24-bit pixel bus and the 3-bit control bus and raises a one-cycle strobe. A frame that fails parity raises a one-cycle error pulse instead. The buses then keep the last good word for another pixel period. While frame alignment is not established, nothing reaches the buses.

Alignment is gained after a run of correctly marked frames. It is lost after a run of marker violations, and the hunt for the frame boundary then restarts one bit position at a time.

Top module: `serpix_rx`

## Requirements
- R1: While `rst_n` is low, `pix_out` and `ctl_out` are zero, `word_valid` and `parity_err` are low, and alignment is cleared.
- R2: A frame is sent in this order, one bit per clock: a start bit of 1, pixel bits 23 down to 0, control bits 2 down to 0, a parity bit, and a stop bit of 0. An accepted frame appears on `pix_out` and `ctl_out` just after the clock edge that samples its stop bit.
- R3: Parity is even: the 24 pixel bits, the 3 control bits and the parity bit together hold an even number of ones. An aligned frame with good parity raises `word_valid` for exactly the cycle after its stop bit is sampled.
- R4: An aligned frame whose parity is wrong raises `parity_err` for one cycle, does not raise `word_valid`, and leaves `pix_out` and `ctl_out` unchanged.
- R5: Alignment is declared at the end of the 4th consecutive frame that shows a start bit of 1 and a stop bit of 0. The first of those frames is found by the bit-by-bit hunt. The 5th frame is the first that can reach the outputs.
- R6: While the receiver is not aligned, `word_valid` and `parity_err` stay low and the buses hold their last value.
- R7: While aligned, a single frame with a wrong start bit or stop bit raises neither pulse, leaves the buses unchanged, and keeps alignment. The next good frame is delivered normally. A frame with correct markers and a parity error ends a run of violations.
- R8: Two consecutive marker violations drop alignment. The hunt then tests every bit position, so a stream that has slipped by one bit is acquired again under R5.
- R9: `word_valid` and `parity_err` are never high in the same cycle, and each lasts one cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, 30 times the pixel rate |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| ser_in | input | 1 | Serial frame data, sampled on the rising edge |
| pix_out | output | 24 | Last accepted pixel word |
| ctl_out | output | 3 | Last accepted control bits |
| word_valid | output | 1 | One-cycle strobe for an accepted frame |
| parity_err | output | 1 | One-cycle pulse for a frame rejected by parity |

## Verification
Some properties are checked on every cycle:
- the two pulses exclude each other and never last longer than one cycle;
- the buses never move without a strobe;
- a pulse only follows a cycle in which the receiver was aligned;
- every delivered word agrees in parity with the parity bit on the wire two cycles earlier.

Other behaviour only the bench scenarios can show:
- that alignment needs exactly four marked frames;
- that one marker violation is tolerated and two are not;
- that a one-bit slip is reacquired;
- that the bit order lands each field on the right output lines.

// File: rtl/serpix_pkg.sv
package serpix_pkg;

  // Alignment tracker states
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,  // testing every bit position for a marker pair
    ST_CHECK = 2'd1,  // candidate boundary, counting marked frames
    ST_LOCK  = 2'd2   // aligned, frames are delivered
  } sync_st_t;

  // Framing overhead: start, parity, stop
  localparam int unsigned OVERHEAD_BITS = 3;

endpackage

// File: rtl/serpix_shifter.sv
module serpix_shifter #(
  parameter int unsigned FRAME_W = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_in,
  output logic [FRAME_W-1:0] window
);

  localparam int unsigned HIST_W = FRAME_W - 1;

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  // The current input bit completes the window, so a frame can be
  // judged in the same cycle its stop bit arrives.
  assign hist_d = {hist_q[HIST_W-2:0], ser_in};
  assign window = {hist_q, ser_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

endmodule

// File: rtl/serpix_framer.sv
module serpix_framer
  import serpix_pkg::*;
#(
  parameter int unsigned FRAME_W       = 30,
  parameter int unsigned LOCK_FRAMES   = 4,  // must be at least 2
  parameter int unsigned UNLOCK_FRAMES = 2   // must be at least 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic marks_ok,   // start and stop markers correct in window
  output logic take,       // aligned frame boundary with good markers
  output logic locked
);

  localparam int unsigned CW = $clog2(FRAME_W);
  localparam int unsigned GW = $clog2(LOCK_FRAMES + 1);
  localparam int unsigned BW = $clog2(UNLOCK_FRAMES + 1);
  localparam logic [CW-1:0] CNT_LAST  = CW'(FRAME_W - 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_FRAMES - 1);
  localparam logic [BW-1:0] BAD_LAST  = BW'(UNLOCK_FRAMES - 1);
  localparam logic [GW-1:0] GOOD_ONE  = GW'(1);

  sync_st_t      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [GW-1:0] good_q, good_d;
  logic [BW-1:0] bad_q, bad_d;
  logic          at_end;
  logic          tally_en;

  assign at_end   = (cnt_q == CNT_LAST);
  // Frame tallies only move on a frame boundary or during the hunt
  assign tally_en = at_end || (st_q == ST_HUNT);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    good_d = good_q;
    bad_d  = bad_q;
    take   = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        cnt_d = '0;
        if (marks_ok) begin
          st_d   = ST_CHECK;
          good_d = GOOD_ONE;
        end
      end
      ST_CHECK: begin
        cnt_d = at_end ? '0 : cnt_q + 1'b1;
        if (at_end) begin
          if (marks_ok) begin
            good_d = good_q + 1'b1;
            if (good_q == GOOD_LAST) begin
              st_d  = ST_LOCK;
              bad_d = '0;
            end
          end else begin
            st_d = ST_HUNT;
          end
        end
      end
      ST_LOCK: begin
        cnt_d = at_end ? '0 : cnt_q + 1'b1;
        if (at_end) begin
          if (marks_ok) begin
            bad_d = '0;
            take  = 1'b1;
          end else begin
            bad_d = bad_q + 1'b1;
            if (bad_q == BAD_LAST) begin
              st_d = ST_HUNT;
            end
          end
        end
      end
      default: begin
        st_d  = ST_HUNT;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      bad_q  <= '0;
    end else if (tally_en) begin
      good_q <= good_d;
      bad_q  <= bad_d;
    end
  end

  assign locked = (st_q == ST_LOCK);

endmodule

// File: rtl/serpix_capture.sv
module serpix_capture #(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned CTL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [CTL_W-1:0] ctl_in,
  input  logic             par_in,
  output logic [PIX_W-1:0] pix_out,
  output logic [CTL_W-1:0] ctl_out,
  output logic             word_valid,
  output logic             parity_err
);

  logic par_good;
  logic load;
  logic reject;

  // Even parity: data plus parity bit must hold an even count of ones
  assign par_good = ~(^{pix_in, ctl_in, par_in});
  assign load     = take & par_good;
  assign reject   = take & ~par_good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out <= '0;
      ctl_out <= '0;
    end else if (load) begin
      pix_out <= pix_in;
      ctl_out <= ctl_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      word_valid <= load;
      parity_err <= reject;
    end
  end

endmodule

// File: rtl/serpix_rx.sv
module serpix_rx
  import serpix_pkg::*;
#(
  parameter int unsigned PIX_W         = 24,
  parameter int unsigned CTL_W         = 3,
  parameter int unsigned LOCK_FRAMES   = 4,
  parameter int unsigned UNLOCK_FRAMES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  output logic [PIX_W-1:0] pix_out,
  output logic [CTL_W-1:0] ctl_out,
  output logic             word_valid,
  output logic             parity_err
);

  localparam int unsigned FRAME_W = PIX_W + CTL_W + OVERHEAD_BITS;
  // Window field positions: start at the top, stop at bit 0
  localparam int unsigned START_POS = FRAME_W - 1;
  localparam int unsigned PIX_LSB   = CTL_W + 2;
  localparam int unsigned CTL_LSB   = 2;
  localparam int unsigned PAR_POS   = 1;

  logic [FRAME_W-1:0] window;
  logic               marks_ok;
  logic               take;
  logic               locked;

  serpix_shifter #(
    .FRAME_W(FRAME_W)
  ) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .ser_in(ser_in),
    .window(window)
  );

  assign marks_ok = window[START_POS] & ~window[0];

  serpix_framer #(
    .FRAME_W      (FRAME_W),
    .LOCK_FRAMES  (LOCK_FRAMES),
    .UNLOCK_FRAMES(UNLOCK_FRAMES)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .marks_ok(marks_ok),
    .take    (take),
    .locked  (locked)
  );

  serpix_capture #(
    .PIX_W(PIX_W),
    .CTL_W(CTL_W)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .pix_in    (window[PIX_LSB +: PIX_W]),
    .ctl_in    (window[CTL_LSB +: CTL_W]),
    .par_in    (window[PAR_POS]),
    .pix_out   (pix_out),
    .ctl_out   (ctl_out),
    .word_valid(word_valid),
    .parity_err(parity_err)
  );

endmodule

// File: rtl/serpix_rx_chk.sv
module serpix_rx_chk #(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned CTL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_in,
  input logic [PIX_W-1:0] pix_out,
  input logic [CTL_W-1:0] ctl_out,
  input logic             word_valid,
  input logic             parity_err,
  input logic             locked
);

  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && parity_err));

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  assert_perr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |=> !parity_err);

  // Buses move only together with the strobe (R4, R6, R7)
  assert_bus_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable({pix_out, ctl_out}));

  assert_aligned_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid || parity_err) |-> $past(locked));

  // Parity bit arrived two cycles before the strobe is seen
  assert_even_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> ((^{pix_out, ctl_out}) == $past(ser_in, 2)));

endmodule

bind serpix_rx serpix_rx_chk #(
  .PIX_W(PIX_W),
  .CTL_W(CTL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_in    (ser_in),
  .pix_out   (pix_out),
  .ctl_out   (ctl_out),
  .word_valid(word_valid),
  .parity_err(parity_err),
  .locked    (locked)
);

// File: tb/serpix_rx_bench.sv
module serpix_rx_bench;

  logic        clk;
  logic        rst_n;
  logic        ser_in;
  logic [23:0] pix_out;
  logic [2:0]  ctl_out;
  logic        word_valid;
  logic        parity_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [23:0] e_pix;
  logic [2:0]  e_ctl;

  // Entry: {kind, ctl, pix}; kind 0 good, 1 parity wrong,
  // 2 start bit wrong, 3 stop bit wrong. No two violations in a row.
  localparam logic [28:0] VEC [13] = '{
    {2'd0, 3'b101, 24'hA5C30F},
    {2'd0, 3'b010, 24'h123456},
    {2'd1, 3'b111, 24'hFFFFFF},
    {2'd0, 3'b000, 24'h800001},
    {2'd2, 3'b011, 24'h00FF00},
    {2'd0, 3'b110, 24'h7E7E7E},
    {2'd3, 3'b001, 24'hDEADBE},
    {2'd1, 3'b100, 24'h000001},
    {2'd0, 3'b001, 24'hC0FFEE},
    {2'd3, 3'b000, 24'h0F0F0F},
    {2'd1, 3'b010, 24'h333333},
    {2'd2, 3'b101, 24'h111111},
    {2'd0, 3'b111, 24'h5A5A5A}
  };

  serpix_rx u_serpix_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_in    (ser_in),
    .pix_out   (pix_out),
    .ctl_out   (ctl_out),
    .word_valid(word_valid),
    .parity_err(parity_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [29:0] build(input logic [1:0] kind, input logic [2:0] ctl,
                                        input logic [23:0] pix);
    logic p;
    p = (^{pix, ctl}) ^ (kind == 2'd1);
    return {kind != 2'd2, pix, ctl, p, kind == 2'd3};
  endfunction

  // Called at a falling edge; returns at the next falling edge
  task automatic send_bit(input logic b);
    ser_in = b;
    @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] kind, input logic [2:0] ctl,
                       input logic [23:0] pix, input logic lk);
    logic [29:0] f;
    logic        ev;
    logic        ep;
    string       tag;
    f  = build(kind, ctl, pix);
    ev = lk && (kind == 2'd0);
    ep = lk && (kind == 2'd1);
    if (!lk)              tag = "R6";
    else if (kind >= 2'd2) tag = "R7";
    else if (kind == 2'd1) tag = "R4";
    else                   tag = "R2";
    if (ev) begin
      e_pix = pix;
      e_ctl = ctl;
    end
    for (int i = 29; i >= 0; i--) begin
      send_bit(f[i]);
      if (i == 29) check("R9", {30'd0, word_valid, parity_err}, 32'd0);
    end
    check(ev ? "R3" : tag, {31'd0, word_valid}, {31'd0, ev});
    check(ep ? "R4" : tag, {31'd0, parity_err}, {31'd0, ep});
    check(tag, {8'd0, pix_out}, {8'd0, e_pix});
    check(tag, {29'd0, ctl_out}, {29'd0, e_ctl});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R9 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    ser_in = 1'b0;
    e_pix  = '0;
    e_ctl  = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {8'd0, pix_out}, 32'd0);
    check("R1", {29'd0, ctl_out}, 32'd0);
    check("R1", {30'd0, word_valid, parity_err}, 32'd0);
    rst_n = 1'b1;

    // R5: four marked frames to align, none delivered
    for (int k = 0; k < 4; k++) frame(2'd0, 3'd0, 24'd0, 1'b0);

    // Vector walk while aligned
    foreach (VEC[n]) begin
      frame(VEC[n][28:27], VEC[n][26:24], VEC[n][23:0], 1'b1);
      if (n == 0) check("R5", {31'd0, word_valid}, 32'd1);
    end

    // R8: two violations in a row, then a one-bit slip
    frame(2'd2, 3'd0, 24'd0, 1'b1);
    frame(2'd2, 3'd0, 24'd0, 1'b1);
    send_bit(1'b0);
    for (int k = 0; k < 4; k++) frame(2'd0, 3'd0, 24'd0, 1'b0);
    frame(2'd0, 3'b010, 24'h13579B, 1'b1);
    check("R8", {8'd0, pix_out}, 32'h0013579B);

    // R1: reset in mid-stream, then acquire again
    rst_n = 1'b0;
    @(negedge clk);
    e_pix = '0;
    e_ctl = '0;
    check("R1", {8'd0, pix_out}, 32'd0);
    check("R1", {29'd0, ctl_out}, 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) frame(2'd0, 3'd0, 24'd0, 1'b0);
    frame(2'd0, 3'b100, 24'h2468AC, 1'b1);
    check("R5", {31'd0, word_valid}, 32'd1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule